// File: doc/BRIEF.md
# Interrupt Acceptance and Restart Sequencer

This block is the interrupt-control slice of a small multicycle processor. Every instruction passes through three execution stages. In the last stage the sequencer looks at two request lines: a restart request and an ordinary device request. It takes a request only if the interrupt-enable bit is set. Requests arriving at any other moment, or while the bit is clear, leave execution untouched, and the next instruction fetch follows as usual.

A device request is served in two extra cycles. In the first, the sequencer copies the current program counter into a saved-PC register and reads the device's vector entry. The vector table sits at the bottom of memory, so the entry for device n is at address n. In the second cycle, the word that comes back is loaded into the program counter and the request is acknowledged.

A restart request takes one extra cycle. That cycle clears every data register and loads the program counter with a fixed start address, 0x40FF by default. No handler is fetched and the saved PC is left alone. Accepting either kind of request clears the enable bit. A return-from-interrupt strobe sets it again.

Top module: `irq_sequencer`

## Requirements
- R1: After hardware reset the stage index is 0 (stage indices 0, 1 and 2 stand for execution stages 1, 2 and 3), the interrupt-enable bit reads 1, saved_pc is 0 and every strobe is low. Outside dispatch the stage index advances 0→1→2→0 once per cycle. During dispatch it holds at 0.
- R2: Requests are sampled only in the cycle whose stage index is 2. A request that is present only in stage 0 or 1 and gone by stage 2 causes no dispatch.
- R3: While the enable bit is 0, both the restart request and the device request are ignored. The stage index wraps from 2 to 0 and no strobe is raised.
- R4: An accepted restart request gives exactly one following cycle with regs_clear=1, pc_load=1 and pc_load_val=0x40FF. In that cycle mem_rd, pc_save and irq_ack are 0, and saved_pc keeps its value.
- R5: An accepted device request gives a first dispatch cycle with pc_save=1 and mem_rd=1. In that cycle mem_addr is the 4-bit device ID captured at acceptance, zero-extended to 16 bits. saved_pc then holds the pc_cur value seen in that cycle.
- R6: The second device dispatch cycle has pc_load=1, irq_ack=1 and pc_load_val equal to mem_rdata, which is the vector word returned one cycle after the read. Stage 0 of the next instruction follows.
- R7: Acceptance clears the enable bit at the acceptance edge. rti_strobe sets it at the next edge. When rti_strobe coincides with an acceptance, the bit ends up cleared.
- R8: When restart and device requests meet at the same enabled boundary, the restart is served and the device is not acknowledged. A device request still held is served after the enable bit is set again.
- R9: Outside dispatch, regs_clear, pc_load, pc_save, mem_rd and irq_ack are 0, and pc_load_val and mem_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| irq_req | input | 1 | Device interrupt request (level) |
| irq_dev_id | input | 4 | ID of the requesting device |
| rst_irq | input | 1 | Restart interrupt request (level) |
| rti_strobe | input | 1 | Return-from-interrupt, sets the enable bit |
| pc_cur | input | 16 | Current program counter |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_rd |
| stage_idx | output | 2 | Execution stage index (0..2) |
| ien | output | 1 | Interrupt-enable bit |
| regs_clear | output | 1 | Clear all data registers |
| pc_load | output | 1 | Load program counter with pc_load_val |
| pc_load_val | output | 16 | Value for the program counter |
| pc_save | output | 1 | Program counter is being saved |
| saved_pc | output | 16 | Saved program counter |
| mem_rd | output | 1 | Vector read strobe |
| mem_addr | output | 16 | Vector read address |
| irq_ack | output | 1 | Device interrupt acknowledge |

## Verification
Two functions can fall on the same boundary: the restart dispatch and the device dispatch, when both request lines are high in the stage-2 cycle with the enable bit set. The bench raises both lines together. It expects the single restart cycle, no acknowledge, and the held device request served only after a later return strobe. A second collision, a return strobe in the same cycle as an acceptance, is provoked on purpose and judged by the enable bit reading 0 afterwards. A behavioural model compares every output on every cycle through directed phases and a long random phase, where both collisions also occur by chance.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_SAVE  = 2'd1,
    PH_LOAD  = 2'd2,
    PH_CLEAR = 2'd3
  } phase_e;

  // next stage index with wrap at n
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // priority pick at a boundary: restart beats device
  function automatic logic [1:0] pick(logic en, logic at_edge, logic r, logic d);
    logic [1:0] res;
    res = 2'b00;
    if (en && at_edge) begin
      if (r)      res = 2'b10;
      else if (d) res = 2'b01;
    end
    return res;
  endfunction

endpackage

// File: rtl/irq_stage_ctr.sv
module irq_stage_ctr #(
  parameter int STAGES = 3,
  localparam int STG_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [STG_W-1:0] stage,
  output logic             last
);
  logic [STG_W-1:0] stage_q;

  assign last  = (stage_q == STG_W'(STAGES - 1));
  assign stage = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (advance) stage_q <= STG_W'(irq_seq_pkg::wrap_inc(int'(stage_q), STAGES));
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter bit IEN_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic irq_req,
  input  logic rst_irq,
  input  logic rti_strobe,
  output logic take_rst,
  output logic take_dev,
  output logic ien
);
  logic       ien_q;
  logic [1:0] sel;

  assign sel      = irq_seq_pkg::pick(ien_q, boundary, rst_irq, irq_req);
  assign take_rst = sel[1];
  assign take_dev = sel[0];
  assign ien      = ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ien_q <= IEN_INIT;
    else if (take_rst | take_dev) ien_q <= 1'b0;
    else if (rti_strobe)         ien_q <= 1'b1;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h40FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_rst,
  input  logic              take_dev,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              regs_clear,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val,
  output logic              pc_save,
  output logic [ADDR_W-1:0] saved_pc,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              irq_ack
);
  phase_e            phase_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] saved_q;
  logic [ADDR_W-1:0] vec_addr;

  generate
    if (ADDR_W > ID_W) begin : g_ext
      assign vec_addr = {{(ADDR_W - ID_W){1'b0}}, id_q};
    end else begin : g_trunc
      assign vec_addr = id_q[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      id_q    <= '0;
      saved_q <= '0;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          if (take_rst) phase_q <= PH_CLEAR;
          else if (take_dev) begin
            phase_q <= PH_SAVE;
            id_q    <= dev_id;
          end
        end
        PH_SAVE: begin
          saved_q <= pc_cur;
          phase_q <= PH_LOAD;
        end
        PH_LOAD:  phase_q <= PH_RUN;
        PH_CLEAR: phase_q <= PH_RUN;
        default:  phase_q <= PH_RUN;
      endcase
    end
  end

  always_comb begin
    regs_clear  = 1'b0;
    pc_load     = 1'b0;
    pc_load_val = '0;
    pc_save     = 1'b0;
    mem_rd      = 1'b0;
    mem_addr    = '0;
    irq_ack     = 1'b0;
    unique case (phase_q)
      PH_SAVE: begin
        pc_save  = 1'b1;
        mem_rd   = 1'b1;
        mem_addr = vec_addr;
      end
      PH_LOAD: begin
        pc_load     = 1'b1;
        pc_load_val = mem_rdata;
        irq_ack     = 1'b1;
      end
      PH_CLEAR: begin
        regs_clear  = 1'b1;
        pc_load     = 1'b1;
        pc_load_val = RESET_PC;
      end
      default: ;
    endcase
  end

  assign busy     = (phase_q != PH_RUN);
  assign saved_pc = saved_q;
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int ADDR_W = 16,
  parameter int ID_W = 4,
  parameter int STAGES = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h40FF,
  parameter bit IEN_INIT = 1'b1,
  localparam int STG_W = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [ID_W-1:0]   irq_dev_id,
  input  logic              rst_irq,
  input  logic              rti_strobe,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [STG_W-1:0]  stage_idx,
  output logic              ien,
  output logic              regs_clear,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val,
  output logic              pc_save,
  output logic [ADDR_W-1:0] saved_pc,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              irq_ack
);
  // named internal events, also used by the bound checker
  logic busy;
  logic last_stage;
  logic boundary;
  logic take_rst;
  logic take_dev;

  assign boundary = last_stage & ~busy;

  irq_stage_ctr #(.STAGES(STAGES)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (~busy),
    .stage   (stage_idx),
    .last    (last_stage)
  );

  irq_accept #(.IEN_INIT(IEN_INIT)) u_accept (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .irq_req    (irq_req),
    .rst_irq    (rst_irq),
    .rti_strobe (rti_strobe),
    .take_rst   (take_rst),
    .take_dev   (take_dev),
    .ien        (ien)
  );

  irq_dispatch #(.ADDR_W(ADDR_W), .ID_W(ID_W), .RESET_PC(RESET_PC)) u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_rst    (take_rst),
    .take_dev    (take_dev),
    .dev_id      (irq_dev_id),
    .pc_cur      (pc_cur),
    .mem_rdata   (mem_rdata),
    .busy        (busy),
    .regs_clear  (regs_clear),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val),
    .pc_save     (pc_save),
    .saved_pc    (saved_pc),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .irq_ack     (irq_ack)
  );
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int ADDR_W = 16,
  parameter int STG_W = 2,
  parameter int STAGES = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h40FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STG_W-1:0]  stage_idx,
  input logic              ien,
  input logic              regs_clear,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_load_val,
  input logic              pc_save,
  input logic [ADDR_W-1:0] saved_pc,
  input logic              mem_rd,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] pc_cur,
  input logic              rst_irq,
  input logic              boundary
);
  assert_stage_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stage_idx < STG_W'(STAGES));

  assert_sample_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_save) || $rose(regs_clear) |-> $past(stage_idx) == STG_W'(STAGES - 1));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !ien) |=> !pc_save && !regs_clear);

  assert_restart_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clear |-> pc_load && pc_load_val == RESET_PC && !mem_rd && !irq_ack);

  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clear |=> !regs_clear && $stable(saved_pc));

  assert_save_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_save |=> saved_pc == $past(pc_cur));

  assert_save_then_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_save |=> pc_load && irq_ack && !pc_save);

  assert_dispatch_clears_ien_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_save || regs_clear) |-> !ien);

  assert_restart_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ien && rst_irq) |=> regs_clear && !pc_save);

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regs_clear, pc_save, irq_ack}));
endmodule

bind irq_sequencer irq_sequencer_chk #(
  .ADDR_W(ADDR_W), .STG_W(STG_W), .STAGES(STAGES), .RESET_PC(RESET_PC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stage_idx   (stage_idx),
  .ien         (ien),
  .regs_clear  (regs_clear),
  .pc_load     (pc_load),
  .pc_load_val (pc_load_val),
  .pc_save     (pc_save),
  .saved_pc    (saved_pc),
  .mem_rd      (mem_rd),
  .irq_ack     (irq_ack),
  .pc_cur      (pc_cur),
  .rst_irq     (rst_irq),
  .boundary    (boundary)
);

// File: tb/irq_sequencer_test.sv
`timescale 1ns/1ps
module irq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [3:0]  irq_dev_id = '0;
  logic        rst_irq = 1'b0;
  logic        rti_strobe = 1'b0;
  logic [15:0] pc_cur = 16'h0123;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  stage_idx;
  logic        ien, regs_clear, pc_load, pc_save, mem_rd, irq_ack;
  logic [15:0] pc_load_val, saved_pc, mem_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state: mode 0 run, 1 save, 2 load, 3 restart
  int       m_stage = 0;
  int       m_mode = 0;
  bit       m_ien = 1;
  int       m_id = 0;
  int       m_saved = 0;
  int       n_save = 0, n_clear = 0, n_ack = 0;

  always #10 clk = ~clk;

  irq_sequencer uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_dev_id(irq_dev_id),
    .rst_irq(rst_irq), .rti_strobe(rti_strobe), .pc_cur(pc_cur),
    .mem_rdata(mem_rdata), .stage_idx(stage_idx), .ien(ien),
    .regs_clear(regs_clear), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_save(pc_save), .saved_pc(saved_pc), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .irq_ack(irq_ack)
  );

  function automatic int vec_word(int a);
    return (16'h1000 + a * 16'h0111) & 16'hFFFF;
  endfunction

  // memory: data one cycle after the read
  always @(posedge clk) if (mem_rd) mem_rdata <= 16'(vec_word(int'(mem_addr)));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update on each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_mode = 0; m_ien = 1; m_id = 0; m_saved = 0;
    end else begin
      if (pc_save) n_save++;
      if (regs_clear) n_clear++;
      if (irq_ack) n_ack++;
      case (m_mode)
        0: begin
          if (m_stage == 2) begin
            m_stage = 0;
            if (m_ien && rst_irq) begin m_mode = 3; m_ien = 0; end
            else if (m_ien && irq_req) begin m_mode = 1; m_ien = 0; m_id = int'(irq_dev_id); end
            else if (rti_strobe) m_ien = 1;
          end else begin
            m_stage = m_stage + 1;
            if (rti_strobe) m_ien = 1;
          end
        end
        1: begin m_saved = int'(pc_cur); m_mode = 2; if (rti_strobe) m_ien = 1; end
        default: begin m_mode = 0; if (rti_strobe) m_ien = 1; end
      endcase
    end
  end

  // full comparison every cycle
  always @(negedge clk) if (rst_n && !done) begin
    check("R1", "stage_idx", int'(stage_idx), m_stage);
    check("R7", "ien", int'(ien), int'(m_ien));
    check("R4", "regs_clear", int'(regs_clear), int'(m_mode == 3));
    check("R5", "pc_save", int'(pc_save), int'(m_mode == 1));
    check("R5", "mem_rd", int'(mem_rd), int'(m_mode == 1));
    check("R5", "mem_addr", int'(mem_addr), (m_mode == 1) ? m_id : 0);
    check("R5", "saved_pc", int'(saved_pc), m_saved);
    check("R6", "irq_ack", int'(irq_ack), int'(m_mode == 2));
    check("R9", "pc_load", int'(pc_load), int'(m_mode == 2 || m_mode == 3));
    check("R6", "pc_load_val", int'(pc_load_val),
          (m_mode == 3) ? 16'h40FF : (m_mode == 2) ? vec_word(m_id) : 0);
  end

  task automatic to_stage(int s);
    do @(negedge clk); while (!(int'(stage_idx) == s && m_mode == 0));
  endtask

  task automatic wait_ack();
    do @(negedge clk); while (!irq_ack);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rti_pulse();
    rti_strobe = 1'b1; @(negedge clk); rti_strobe = 1'b0;
  endtask

  initial begin
    int s0, c0, a0;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, before first active edge
    check("R1", "reset stage", int'(stage_idx), 0);
    check("R1", "reset ien", int'(ien), 1);
    check("R1", "reset strobes", int'({regs_clear, pc_load, pc_save, mem_rd, irq_ack}), 0);
    idle(4);

    // device interrupt, id 5
    to_stage(0); irq_req = 1'b1; irq_dev_id = 4'd5;
    wait_ack(); irq_req = 1'b0;
    check("R6", "vector loaded id5", int'(pc_load_val), vec_word(5));
    check("R5", "saved pc id5", int'(saved_pc), 16'h0123);

    // enable clear: both requests ignored
    s0 = n_save; c0 = n_clear;
    irq_req = 1'b1; irq_dev_id = 4'd9; rst_irq = 1'b1;
    idle(12);
    irq_req = 1'b0; rst_irq = 1'b0;
    idle(1);
    check("R3", "no device dispatch while disabled", n_save - s0, 0);
    check("R3", "no restart while disabled", n_clear - c0, 0);

    rti_pulse();
    check("R7", "ien set by rti", int'(ien), 1);

    // pulse gone before stage 2
    s0 = n_save;
    to_stage(0); irq_req = 1'b1; irq_dev_id = 4'd2;
    @(negedge clk); irq_req = 1'b0;
    idle(6);
    check("R2", "early pulse ignored", n_save - s0, 0);

    // restart and device at same boundary
    pc_cur = 16'h0777;
    to_stage(0); rst_irq = 1'b1; irq_req = 1'b1; irq_dev_id = 4'd3;
    s0 = n_save; a0 = n_ack;
    do @(negedge clk); while (!regs_clear);
    check("R4", "restart pc value", int'(pc_load_val), 16'h40FF);
    rst_irq = 1'b0;
    idle(8);
    check("R8", "device not served with restart", n_ack - a0, 0);
    check("R8", "device pending not saved", n_save - s0, 0);
    check("R4", "restart keeps saved pc", int'(saved_pc), 16'h0123);
    rti_pulse();
    wait_ack(); irq_req = 1'b0;
    check("R8", "pending device served later", int'(pc_load_val), vec_word(3));
    check("R5", "saved pc after later dispatch", int'(saved_pc), 16'h0777);

    // rti coinciding with acceptance
    rti_pulse();
    to_stage(2); irq_req = 1'b1; irq_dev_id = 4'd12; rti_strobe = 1'b1;
    @(negedge clk); rti_strobe = 1'b0;
    wait_ack(); irq_req = 1'b0;
    idle(2);
    check("R7", "accept wins over rti", int'(ien), 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      irq_req    = ($urandom % 4) == 0;
      rst_irq    = ($urandom % 16) == 0;
      rti_strobe = ($urandom % 8) == 0;
      irq_dev_id = 4'($urandom);
      pc_cur     = 16'($urandom);
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++; done = 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule